// File: doc/BRIEF.md
# Multicore External Interrupt Router

This block takes a set of level-sensitive external interrupt lines and fans them out to a group of processor cores. Software programs it through a small register window. Every core sees the same window, and each access carries the index of the core that issues it. For each line, a routing word selects which cores receive that line. A global enable mask gates the physical line levels. A software-assert mask can raise any line whether or not that line is enabled. Both masks are changed through separate write-one-to-clear and write-one-to-set addresses. Each core's interrupt vector also carries two low-order inter-processor interrupt bits, which come from a separate block.

The same window also holds a run-stall register, with one bit per core, that drives each core's stall pin. After reset only core 0 runs, and software releases the other cores by writing this register. A read-only identity word tells the reading core its own index and the core count. A one-bit control register is kept separately for each core. Line index 0 is reserved and has no pin. Physical lines occupy indices 1 and up.

Top module: `irq_router`

## Requirements
- R1: After reset: the enable mask (read at 0x180) is all ones over the implemented lines, the assert mask (read at 0x188) is 0, every routing word (read at word address n, n < number of lines) is 1, the run-stall register (read at 0x200) is 2^NCORE−2, every per-core control bit (read at 0x220) is 0, and all interrupt outputs are 0.
- R2: A write to address n (n < NEXT+1) stores the low NCORE bits of the data as the routing word of line n, where bit c selects core c. A read of that address returns the word. Writes to addresses 0..31 at or above NEXT+1 are ignored, and reads of those addresses return 0.
- R3: Writing ones to 0x180 clears those bits of the enable mask. Writing ones to 0x184 sets them. Bits written as zero keep their value.
- R4: Writing ones to 0x188 clears those bits of the assert mask. Writing ones to 0x18C sets them. A read of 0x188 returns the mask.
- R5: Core c's output vector bits [NEXT+2:2] equal (((line state AND enable) OR assert) AND the lines routed to c). Line k, for k ≥ 1, is driven by pin line_in[k−1], and line 0 has a state of 0. The output changes on the first clock edge after the change that causes it.
- R6: Bits [1:0] of core c's output vector repeat ipi_in[2c+1:2c] one clock later.
- R7: A line whose assert bit is set reaches its routed cores even if its enable bit is 0.
- R8: A write to 0x200 loads the low NCORE bits of the data into the run-stall register. That register drives stall_out, and a read of 0x200 returns it.
- R9: A read of 0x1A0 returns ((NCORE−1) << 18) OR the index of the requesting core.
- R10: A write to 0x220 stores bit 0 of the data in the requesting core's own control bit. A read of 0x220 returns only the requesting core's bit.
- R11: Reads of any other address, including the set addresses 0x184 and 0x18C, return 0. Writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CW | Index of the core making the access |
| req_addr | input | 10 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current address, combinational |
| line_in | input | NEXT | External interrupt levels; bit k−1 is line k |
| ipi_in | input | 2*NCORE | Inter-processor interrupt bits, two per core |
| irq_out | output | NCORE*(NEXT+3) | Registered interrupt vector per core, core c at [c*(NEXT+3) +: NEXT+3] |
| stall_out | output | NCORE | Run-stall per core |

## Verification
The hardest case to reach is an output bit that depends on the enable mask, the assert mask, a non-default route and a live line level all at once. A vector that gives the right result while one of these terms is ignored would hide the fault. The stimulus table therefore first leaves the enable mask with holes in it, sets an assert bit on an enabled line, and moves that line onto cores other than core 0. The directed tests then raise pins on enabled and disabled lines, assert a disabled line, and re-route a line, checking every core's vector after each step. The one-clock output latency is checked by sampling just after a pin changes, before the next edge, and again after that edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W = 10;

  // register word addresses
  localparam logic [ADDR_W-1:0] ADR_ROUTE_END = 10'h020;
  localparam logic [ADDR_W-1:0] ADR_EN_CLR    = 10'h180;
  localparam logic [ADDR_W-1:0] ADR_EN_SET    = 10'h184;
  localparam logic [ADDR_W-1:0] ADR_ASG_CLR   = 10'h188;
  localparam logic [ADDR_W-1:0] ADR_ASG_SET   = 10'h18C;
  localparam logic [ADDR_W-1:0] ADR_ID        = 10'h1A0;
  localparam logic [ADDR_W-1:0] ADR_STALL     = 10'h200;
  localparam logic [ADDR_W-1:0] ADR_CCTL      = 10'h220;

  localparam int ID_CNT_SHIFT = 18;
  localparam int IPI_W        = 2;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 8,
  parameter int CW    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [CW-1:0]          req_core,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic [31:0]            rdata,
  output logic [NLINE-1:0]       en_mask,
  output logic [NLINE-1:0]       asg_mask,
  output logic [NLINE*NCORE-1:0] route_flat,
  output logic [NCORE-1:0]       stall
);
  localparam logic [NCORE-1:0] STALL_RST = ~(NCORE'(1));
  localparam logic [NCORE-1:0] ROUTE_RST = NCORE'(1);

  logic [NCORE-1:0] route_q [NLINE];
  logic [NCORE-1:0] route_d [NLINE];
  logic [NLINE-1:0] en_q, en_d, asg_q, asg_d;
  logic [NCORE-1:0] stall_q, stall_d, cctl_q, cctl_d;
  logic             wr;
  logic [NLINE-1:0] wlines;

  assign wr     = req_valid & req_write;
  assign wlines = req_wdata[NLINE-1:0];

  // next-state
  always_comb begin
    en_d    = en_q;
    asg_d   = asg_q;
    stall_d = stall_q;
    cctl_d  = cctl_q;
    for (int n = 0; n < NLINE; n++) begin
      route_d[n] = route_q[n];
      if (wr && req_addr == ADDR_W'(n)) route_d[n] = req_wdata[NCORE-1:0];
    end
    if (wr) begin
      case (req_addr)
        ADR_EN_CLR:  en_d    = en_q & ~wlines;
        ADR_EN_SET:  en_d    = en_q | wlines;
        ADR_ASG_CLR: asg_d   = asg_q & ~wlines;
        ADR_ASG_SET: asg_d   = asg_q | wlines;
        ADR_STALL:   stall_d = req_wdata[NCORE-1:0];
        ADR_CCTL: begin
          for (int c = 0; c < NCORE; c++)
            if (req_core == CW'(c)) cctl_d[c] = req_wdata[0];
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '1;
      asg_q   <= '0;
      stall_q <= STALL_RST;
      cctl_q  <= '0;
      for (int n = 0; n < NLINE; n++) route_q[n] <= ROUTE_RST;
    end else begin
      en_q    <= en_d;
      asg_q   <= asg_d;
      stall_q <= stall_d;
      cctl_q  <= cctl_d;
      for (int n = 0; n < NLINE; n++) route_q[n] <= route_d[n];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (req_addr < ADR_ROUTE_END) begin
      for (int n = 0; n < NLINE; n++)
        if (req_addr == ADDR_W'(n)) rdata[NCORE-1:0] = route_q[n];
    end else begin
      case (req_addr)
        ADR_EN_CLR:  rdata[NLINE-1:0] = en_q;
        ADR_ASG_CLR: rdata[NLINE-1:0] = asg_q;
        ADR_ID:      rdata = (32'(NCORE - 1) << ID_CNT_SHIFT) | 32'(req_core);
        ADR_STALL:   rdata[NCORE-1:0] = stall_q;
        ADR_CCTL: begin
          for (int c = 0; c < NCORE; c++)
            if (req_core == CW'(c)) rdata[0] = cctl_q[c];
        end
        default: rdata = '0;
      endcase
    end
  end

  generate
    for (genvar n = 0; n < NLINE; n++) begin : g_flat
      assign route_flat[n*NCORE +: NCORE] = route_q[n];
    end
  endgenerate

  assign en_mask  = en_q;
  assign asg_mask = asg_q;
  assign stall    = stall_q;
endmodule

// File: rtl/irq_router_lane.sv
module irq_router_lane
  import irq_router_pkg::*;
#(
  parameter int NLINE = 8,
  parameter int OUTW  = NLINE + IPI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] pend,
  input  logic [NLINE-1:0] route_col,
  input  logic [IPI_W-1:0] ipi,
  output logic [OUTW-1:0]  irq_q
);
  logic [OUTW-1:0] irq_d;

  always_comb irq_d = {pend & route_col, ipi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NEXT  = 7,
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int NLINE = NEXT + 1,
  localparam int OUTW  = NLINE + IPI_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [CW-1:0]         req_core,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  output logic [31:0]           rsp_rdata,
  input  logic [NEXT-1:0]       line_in,
  input  logic [IPI_W*NCORE-1:0] ipi_in,
  output logic [NCORE*OUTW-1:0] irq_out,
  output logic [NCORE-1:0]      stall_out
);
  logic                   rst_meta, rst_sync;
  logic [NLINE-1:0]       en_mask, asg_mask, line_state, pend;
  logic [NLINE*NCORE-1:0] route_flat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  irq_router_regs #(.NCORE(NCORE), .NLINE(NLINE), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_core  (req_core),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rdata     (rsp_rdata),
    .en_mask   (en_mask),
    .asg_mask  (asg_mask),
    .route_flat(route_flat),
    .stall     (stall_out)
  );

  // line 0 is reserved and has no pin
  assign line_state = {line_in, 1'b0};
  assign pend       = (line_state & en_mask) | asg_mask;

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      logic [NLINE-1:0] col;
      for (genvar n = 0; n < NLINE; n++) begin : g_col
        assign col[n] = route_flat[n*NCORE + c];
      end
      irq_router_lane #(.NLINE(NLINE), .OUTW(OUTW)) u_lane (
        .clk      (clk),
        .rst_n    (rst_sync),
        .pend     (pend),
        .route_col(col),
        .ipi      (ipi_in[c*IPI_W +: IPI_W]),
        .irq_q    (irq_out[c*OUTW +: OUTW])
      );
    end
  endgenerate
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NEXT  = 7,
  parameter int CW    = 2,
  localparam int NLINE = NEXT + 1,
  localparam int OUTW  = NLINE + IPI_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [CW-1:0]          req_core,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [31:0]            req_wdata,
  input logic [31:0]            rsp_rdata,
  input logic [NLINE-1:0]       en_mask,
  input logic [IPI_W*NCORE-1:0] ipi_in,
  input logic [NCORE*OUTW-1:0]  irq_out,
  input logic [NCORE-1:0]       stall_out
);
  logic wr, rd;
  assign wr = req_valid &  req_write;
  assign rd = req_valid & ~req_write;

  assert_stall_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == ADR_STALL) |=> stall_out == $past(req_wdata[NCORE-1:0]));

  assert_stall_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !(wr && req_addr == ADR_STALL)) |=> $stable(stall_out));

  assert_id_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == ADR_ID) |-> rsp_rdata == ((32'(NCORE - 1) << ID_CNT_SHIFT) | 32'(req_core)));

  assert_set_addr_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (req_addr == ADR_EN_SET || req_addr == ADR_ASG_SET)) |-> rsp_rdata == 32'd0);

  assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == ADR_EN_CLR) |=> (en_mask & $past(req_wdata[NLINE-1:0])) == '0);

  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == ADR_EN_SET) |=>
      (en_mask & $past(req_wdata[NLINE-1:0])) == $past(req_wdata[NLINE-1:0]));

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_ipi
      assert_ipi_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_out[c*OUTW +: IPI_W] == $past(ipi_in[c*IPI_W +: IPI_W]));
    end
  endgenerate
endmodule

bind irq_router irq_router_chk #(.NCORE(NCORE), .NEXT(NEXT), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_core  (req_core),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_rdata (rsp_rdata),
  .en_mask   (en_mask),
  .ipi_in    (ipi_in),
  .irq_out   (irq_out),
  .stall_out (stall_out)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  localparam int NCORE = 4;
  localparam int NEXT  = 7;
  localparam int CW    = 2;
  localparam int OUTW  = NEXT + 3;
  localparam int NV    = 27;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  req_valid, req_write;
  logic [CW-1:0]         req_core;
  logic [9:0]            req_addr;
  logic [31:0]           req_wdata, rsp_rdata;
  logic [NEXT-1:0]       line_in;
  logic [2*NCORE-1:0]    ipi_in;
  logic [NCORE*OUTW-1:0] irq_out;
  logic [NCORE-1:0]      stall_out;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_router #(.NCORE(NCORE), .NEXT(NEXT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .line_in(line_in), .ipi_in(ipi_in),
    .irq_out(irq_out), .stall_out(stall_out)
  );

  // {write, core, addr, wdata, expected read, requirement}
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 2'd0, 10'h180, 32'h0,        32'h000000FF, 4'd1},  // R1 enable all ones
    {1'b0, 2'd0, 10'h188, 32'h0,        32'h00000000, 4'd1},  // R1 assert zero
    {1'b0, 2'd0, 10'h003, 32'h0,        32'h00000001, 4'd1},  // R1 route to core 0
    {1'b0, 2'd0, 10'h200, 32'h0,        32'h0000000E, 4'd1},  // R1 stall reset
    {1'b0, 2'd2, 10'h1A0, 32'h0,        32'h000C0002, 4'd9},  // R9 id word
    {1'b0, 2'd1, 10'h220, 32'h0,        32'h00000000, 4'd1},  // R1 control bit
    {1'b1, 2'd0, 10'h180, 32'h0000000F, 32'h0,        4'd3},
    {1'b0, 2'd0, 10'h180, 32'h0,        32'h000000F0, 4'd3},  // R3 clear
    {1'b1, 2'd1, 10'h184, 32'h00000003, 32'h0,        4'd3},
    {1'b0, 2'd1, 10'h180, 32'h0,        32'h000000F3, 4'd3},  // R3 set
    {1'b1, 2'd0, 10'h18C, 32'h00000021, 32'h0,        4'd4},
    {1'b1, 2'd2, 10'h188, 32'h00000001, 32'h0,        4'd4},
    {1'b0, 2'd0, 10'h188, 32'h0,        32'h00000020, 4'd4},  // R4 set then clear
    {1'b1, 2'd0, 10'h005, 32'h00000006, 32'h0,        4'd2},
    {1'b0, 2'd3, 10'h005, 32'h0,        32'h00000006, 4'd2},  // R2 route readback
    {1'b1, 2'd0, 10'h008, 32'h0000000F, 32'h0,        4'd2},
    {1'b0, 2'd0, 10'h008, 32'h0,        32'h00000000, 4'd2},  // R2 beyond last line
    {1'b1, 2'd3, 10'h220, 32'h000000FF, 32'h0,        4'd10},
    {1'b0, 2'd3, 10'h220, 32'h0,        32'h00000001, 4'd10}, // R10 own bit only bit 0
    {1'b0, 2'd0, 10'h220, 32'h0,        32'h00000000, 4'd10}, // R10 other core untouched
    {1'b1, 2'd0, 10'h300, 32'hFFFFFFFF, 32'h0,        4'd11},
    {1'b0, 2'd0, 10'h300, 32'h0,        32'h00000000, 4'd11}, // R11 unmapped read
    {1'b0, 2'd0, 10'h184, 32'h0,        32'h00000000, 4'd11}, // R11 set address reads 0
    {1'b0, 2'd0, 10'h180, 32'h0,        32'h000000F3, 4'd11}, // R11 unmapped write no effect
    {1'b1, 2'd1, 10'h200, 32'h00000005, 32'h0,        4'd8},
    {1'b0, 2'd2, 10'h200, 32'h0,        32'h00000005, 4'd8},  // R8 stall readback
    {1'b0, 2'd3, 10'h1A0, 32'h0,        32'h000C0003, 4'd9}   // R9 id word
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [CW-1:0] core, input logic [9:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_core = core; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [CW-1:0] core, input logic [9:0] addr, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_core = core; req_addr = addr; req_wdata = '0;
    #1 data = rsp_rdata;
  endtask

  function automatic logic [31:0] core_vec(input int c);
    return 32'(irq_out[c*OUTW +: OUTW]);
  endfunction

  initial begin
    #(20.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_core = '0;
    req_addr = '0; req_wdata = '0; line_in = '0; ipi_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 outputs out of reset
    check("R1 irq_out", 32'(irq_out), 32'h0);
    check("R1 stall_out", 32'(stall_out), 32'hE);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) begin
        do_write(VEC[i][79:78], VEC[i][77:68], VEC[i][67:36]);
      end else begin
        do_read(VEC[i][79:78], VEC[i][77:68], rd);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;

    // state now: enable F3, assert 20, line5 routed to cores 1 and 2, stall 5
    check("R8 stall pins", 32'(stall_out), 32'h5);

    @(negedge clk);
    check("R4 core0", core_vec(0), 32'h000);
    check("R4 core1", core_vec(1), 32'h080);
    check("R4 core2", core_vec(2), 32'h080);
    check("R4 core3", core_vec(3), 32'h000);

    // lines 1 and 2 high; line 2 disabled
    line_in = 7'b0000011;
    @(negedge clk);
    check("R5 enable gates pins", core_vec(0), 32'h008);
    check("R5 core1 unchanged", core_vec(1), 32'h080);

    // assert disabled line 2
    do_write(2'd0, 10'h18C, 32'h4);
    @(negedge clk);
    check("R7 assert beats enable", core_vec(0), 32'h018);

    // one-clock latency
    @(negedge clk);
    line_in = '0;
    #1 check("R5 before edge", core_vec(0), 32'h018);
    @(negedge clk);
    check("R5 after edge", core_vec(0), 32'h010);

    // move line 2 to core 3
    do_write(2'd1, 10'h002, 32'h8);
    @(negedge clk);
    check("R2 reroute core0", core_vec(0), 32'h000);
    check("R2 reroute core3", core_vec(3), 32'h010);

    // inter-processor bits on core 3
    ipi_in = 8'b11_00_00_00;
    @(negedge clk);
    check("R6 ipi core3", core_vec(3), 32'h013);
    check("R6 ipi core0", core_vec(0), 32'h000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule